// File: doc/BRIEF.md
# Serial 1101 Pattern Detector (Mealy, JK state register)

This block watches a one-bit serial stream that is sampled on every rising clock edge. Its `hit` output goes high in the same cycle as the bit that completes the pattern 1101. The four most recent bits, including the bit now on `din`, are what count. Matches may overlap, so the trailing 1 of one match can also be the first bit of the next one.

The state lives in two JK flip-flops. A fixed excitation stage computes their J and K inputs from the present state and the current input bit. `hit` is a Mealy output: it is combinational in the present state and `din`, so it is valid during the cycle and not one clock later. A synchronous active-high reset returns the machine to its idle state.

Top module: `seq1101_det`

## Requirements
- R1: `hit` is 1 in a cycle exactly when the last four bits accepted since reset, counting the present `din` as the newest, read 1,1,0,1 in time order. In every other cycle outside reset it is 0.
- R2: `hit` is combinational in the present state and `din`. Across one cycle in which the state holds, flipping `din` between 1 and 0 flips `hit`.
- R3: State is coded {Q1,Q0}: idle = 00, one "1" seen = 01, "11" seen = 11, "110" seen = 10. After every clock edge outside reset, Q0 equals the `din` sampled at that edge.
- R4: While `rst` is 1 at a rising edge, both flip-flops clear to the idle code 00. A partial match present before the reset is discarded, so a single 1 after reset does not raise `hit`.
- R5: Detection overlaps. The stream 1101101 raises `hit` on its 4th and 7th bits, and after a match the machine sits in the "one 1 seen" state.
- R6: From the "11" state, further 1s keep the machine in that state. A run of several 1s followed by 0,1 still produces exactly one `hit`.
- R7: From the "110" state, a 0 returns to idle. The stream 1100 followed by 1101 gives a single `hit`, on the last bit.
- R8: Each flip-flop obeys JK rules: J=K=0 holds, J=1,K=0 sets, J=0,K=1 clears, J=K=1 toggles. The excitation is J1 = din·Q0, K1 = ¬Q0, J0 = din, K0 = ¬din.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces the idle state |
| din | input | 1 | Serial data bit sampled at each rising edge |
| hit | output | 1 | High in the cycle whose current bit completes 1101 |

## Verification
In an overlapping stream, the cycle that reports a match is also the cycle in which the next match begins. The final 1 of 1101 raises `hit` and at the same time moves the machine into the "one 1 seen" state. Directed streams such as 1101101 and 1101101101 provoke this, and dense random streams biased toward 1s provoke it repeatedly. A four-bit history model in the bench judges every cycle: a missed second pulse or an extra pulse shows up as a miscompare on that cycle.

// File: rtl/seq1101_pkg.sv
`timescale 1ns/1ps
package seq1101_pkg;
    localparam int ST_BITS = 2;

    typedef logic [ST_BITS-1:0] st_code_t;

    localparam st_code_t ST_IDLE = 2'b00;
    localparam st_code_t ST_ONE  = 2'b01;
    localparam st_code_t ST_TWO  = 2'b11;
    localparam st_code_t ST_THR  = 2'b10;

    typedef struct packed {
        logic j;
        logic k;
    } jk_pair_t;
endpackage

// File: rtl/seq1101_jk_stage.sv
`timescale 1ns/1ps
module seq1101_jk_stage (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    typedef struct packed {
        logic bit_v;
    } ff_state_t;

    ff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({j, k})
            2'b00: st_d.bit_v = st_q.bit_v;
            2'b10: st_d.bit_v = 1'b1;
            2'b01: st_d.bit_v = 1'b0;
            default: st_d.bit_v = ~st_q.bit_v;
        endcase
        if (rst) st_d.bit_v = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.bit_v;
endmodule

// File: rtl/seq1101_excite.sv
`timescale 1ns/1ps
module seq1101_excite
    import seq1101_pkg::*;
(
    input  logic                din,
    input  st_code_t            st,
    output jk_pair_t [ST_BITS-1:0] jk,
    output logic                hit
);
    always_comb begin
        // upper bit: set only from ONE with a 1, clear whenever Q0 is 0
        jk[1].j = din & st[0];
        jk[1].k = ~st[0];
        // lower bit follows the input
        jk[0].j = din;
        jk[0].k = ~din;
        // Mealy detect: in "110" state with a 1 arriving
        hit     = din & st[1] & ~st[0];
    end
endmodule

// File: rtl/seq1101_det.sv
`timescale 1ns/1ps
module seq1101_det
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    st_code_t               st_q;
    jk_pair_t [ST_BITS-1:0] jk_d;

    seq1101_excite u_exc (
        .din (din),
        .st  (st_q),
        .jk  (jk_d),
        .hit (hit)
    );

    for (genvar g = 0; g < ST_BITS; g++) begin : g_ff
        seq1101_jk_stage u_ff (
            .clk (clk),
            .rst (rst),
            .j   (jk_d[g].j),
            .k   (jk_d[g].k),
            .q   (st_q[g])
        );
    end
endmodule

// File: rtl/seq1101_chk.sv
`timescale 1ns/1ps
module seq1101_chk
    import seq1101_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     din,
    input logic     hit,
    input st_code_t st
);
    // R4: reset lands in idle
    a_r4_reset_idle: assert property (@(posedge clk)
        rst |=> st == ST_IDLE);

    // R2 / R1: detect only in "110" with a 1 on the input
    a_r2_hit_src: assert property (@(posedge clk) disable iff (rst)
        hit |-> (st == ST_THR && din));

    // R3: Q0 tracks the sampled input
    a_r3_q0_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st[0] == $past(din));

    // R5: after a match the machine is in ONE
    a_r5_overlap: assert property (@(posedge clk) disable iff (rst)
        hit |=> st == ST_ONE);

    // R6: TWO holds under a 1
    a_r6_two_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TWO && din) |=> st == ST_TWO);

    // R7: THR falls back to idle on a 0
    a_r7_thr_zero: assert property (@(posedge clk) disable iff (rst)
        (st == ST_THR && !din) |=> st == ST_IDLE);

    // R8: remaining transitions of the JK excitation
    a_r8_idle_one: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && din) |=> st == ST_ONE);
    a_r8_one_one: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ONE && din) |=> st == ST_TWO);
    a_r8_one_zero: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ONE && !din) |=> st == ST_IDLE);
    a_r8_two_zero: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TWO && !din) |=> st == ST_THR);
endmodule

bind seq1101_det seq1101_chk u_chk (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit),
    .st  (st_q)
);

// File: tb/sim_seq1101_det.sv
`timescale 1ns/1ps
module sim_seq1101_det;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    always #2.5 clk = ~clk;

    seq1101_det u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

    int    n_chk  = 0;
    int    n_fail = 0;
    logic  [2:0] hist = 3'b000;
    bit    exp_q[$];
    string tag_q[$];

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // driver: drive one bit and push its expected hit
    task automatic send_bit(input bit b, input string tag);
        @(negedge clk);
        rst = 1'b0;
        din = b;
        exp_q.push_back({hist, b} == 4'b1101);
        tag_q.push_back(tag);
        hist = {hist[1:0], b};
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1", tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        din  = 1'b0;
        hist = 3'b000;
        @(negedge clk);
        rst  = 1'b0;
    endtask

    // monitor: compare away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (hit !== e) begin
                    n_fail++;
                    $display("FAIL %s: hit=%b expected=%b at %0t", t, hit, e, $time);
                end
            end
        end
    end

    // R2: in-cycle combinational response
    task automatic check_comb();
        // prepare "110"
        send_str("110", "R2");
        @(negedge clk);
        din = 1'b1;
        #1;
        n_chk++;
        if (hit !== 1'b1) begin n_fail++; $display("FAIL R2: hit=%b expected=1", hit); end
        din = 1'b0;
        #1;
        n_chk++;
        if (hit !== 1'b0) begin n_fail++; $display("FAIL R2: hit=%b expected=0", hit); end
        hist = {hist[1:0], 1'b0};
    endtask

    initial begin
        do_reset();
        // R4: reset state: a lone 1 does not detect
        send_bit(1'b1, "R4 reset state");
        do_reset();
        send_str("1101", "R1 basic");
        send_str("1101101", "R5 overlap");
        send_str("1111101", "R6 run of ones");
        send_str("11001101", "R7 back to idle");
        send_str("0000", "R1 zeros");
        // R4: partial match discarded by reset
        send_str("110", "R4 pre-reset");
        do_reset();
        send_bit(1'b1, "R4 after reset");
        send_str("0", "R4 after reset");
        check_comb();
        send_str("1101101101", "R5 triple overlap");
        send_str("10101101", "R8 mixed");
        // random streams, biased and unbiased, with sporadic resets
        for (int i = 0; i < 3000; i++) begin
            if (i % 700 == 699) do_reset();
            if (i < 1500) send_bit($urandom_range(0, 1) == 1, "R1 random");
            else          send_bit($urandom_range(0, 3) != 0, "R8 random dense");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 5ns);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule